// File: doc/BRIEF.md
# In-Order Pipeline Hazard Controller

This block is the central control for a five-stage in-order integer pipeline whose stages run Fetch, Decode1, Decode2, Execute and Writeback. Memory access shares the Execute stage with the ALU. Each cycle the surrounding datapath presents a descriptor for every decode, execute and writeback slot. A descriptor carries the slot's valid bit, its register numbers, whether it writes a register, whether it is a store, whether its address is formed from a register, whether it is a branch, and the resolved branch outcome. From these the controller returns:

- per-stage hold signals;
- bubble injection for the slot ahead of a held stage;
- valid-clearing flushes for the younger slots;
- a fetch redirect;
- three forwarding-mux selects: two for the Execute operands and one for the Decode2 address base.

Three kinds of event stall the front end:

- **Decode1 extra cycle.** Decode1 may need one extra cycle for instructions with several operands.
- **Decode2 extra cycle.** Decode2 may need one extra cycle for indexed addressing or for a displacement combined with an immediate.
- **Address dependency.** A Decode2 address calculation may depend on a result that is still being computed in Execute. The controller then stalls for one cycle and afterwards forwards that result into Decode2.

Dependencies between neighbouring Execute instructions never stall; the controller selects a bypass instead. Branches are predicted not taken and resolved in Execute. The branch target is fetched speculatively while the branch is in Execute. On a taken branch the controller discards the three younger slots, so the target reaches Execute three cycles after the branch. A not-taken branch costs nothing extra.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: When `d1_valid` and `d1_multi_op` are high and no other hold or flush applies, exactly one cycle of `hold_f`, `hold_d1` and `bubble_d2` is produced. The following cycle, with the same instruction still present, has no hold. `d1_multi_op` with `d1_valid` low causes no hold.
- R2: When `d2_valid` is high and either `d2_has_index` or `d2_disp_and_imm` is high, exactly one cycle of `hold_f`, `hold_d1`, `hold_d2` and `bubble_ex` is produced, and `bubble_d2` stays low. When both flags are low, no hold is produced.
- R3: A Decode1 instruction needing an extra cycle that is already held for a cycle by a Decode2 hold needs no further hold once Decode2 advances.
- R4: An Execute operand select is 2'b01 when the Writeback slot writes the same nonzero register. This covers a result produced by Execute in the previous cycle, whether from an ALU operation or a load.
- R5: An Execute operand select is 2'b10 when only the instruction that left Writeback in the previous cycle wrote the register. It is 2'b00 otherwise, and 2'b01 wins when both match.
- R6: Operand B is forwarded under the rules of R4 and R5 when `ex_uses_b` or `ex_is_store` is high (store data). Otherwise its select is 2'b00.
- R7: Register 0 never produces a forwarding select other than 2'b00 and never causes an address hold. An operand whose slot is not valid selects 2'b00.
- R8: A valid Decode2 instruction with `d2_addr_uses_reg` high whose address register equals `ex_dst` is held for one cycle. The Execute instruction must be valid with `ex_writes` high and a nonzero `ex_dst`. The hold raises `hold_f`, `hold_d1`, `hold_d2` and `bubble_ex`. In the next cycle, with the producer in Writeback, `d2_addr_sel` is 2'b01 and no hold is produced.
- R9: In any cycle with a valid taken branch in Execute, `flush_f`, `flush_d1`, `flush_d2`, `redirect_to_target` and `fetch_target_req` are all high. This makes the taken-branch cost 3 cycles.
- R10: A valid not-taken branch in Execute raises `fetch_target_req` only. No flush or redirect follows, so it costs 1 cycle. `fetch_target_req` is low when no valid branch is in Execute.
- R11: A flush overrides every hold and bubble in the same cycle, and decode extra-cycle progress does not survive it. A hard instruction arriving next is held normally.
- R12: After synchronous reset, all holds, bubbles, flushes and selects are low. Any Writeback history seen before reset is forgotten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| d1_valid | input | 1 | Decode1 slot holds an instruction |
| d1_multi_op | input | 1 | Decode1 instruction needs an extra decode cycle |
| d2_valid | input | 1 | Decode2 slot holds an instruction |
| d2_addr_uses_reg | input | 1 | Decode2 address calculation reads a register |
| d2_addr_reg | input | AW | Register read by the Decode2 address calculation |
| d2_has_index | input | 1 | Decode2 address uses an index register |
| d2_disp_and_imm | input | 1 | Decode2 instruction has both a displacement and an immediate |
| ex_valid | input | 1 | Execute slot holds an instruction |
| ex_src_a | input | AW | Execute operand A register |
| ex_src_b | input | AW | Execute operand B register |
| ex_uses_b | input | 1 | Execute reads operand B as an ALU input |
| ex_is_store | input | 1 | Execute is a store; operand B is store data |
| ex_dst | input | AW | Execute destination register |
| ex_writes | input | 1 | Execute writes a register (ALU or load) |
| ex_is_branch | input | 1 | Execute is a conditional branch |
| ex_taken | input | 1 | Resolved branch outcome |
| wb_valid | input | 1 | Writeback slot holds an instruction |
| wb_dst | input | AW | Writeback destination register |
| wb_writes | input | 1 | Writeback writes a register |
| hold_f | output | 1 | Freeze Fetch |
| hold_d1 | output | 1 | Freeze Decode1 |
| hold_d2 | output | 1 | Freeze Decode2 |
| bubble_d2 | output | 1 | Load an empty slot into Decode2 |
| bubble_ex | output | 1 | Load an empty slot into Execute |
| flush_f | output | 1 | Clear the valid bit of the Fetch slot |
| flush_d1 | output | 1 | Clear the valid bit of the Decode1 slot |
| flush_d2 | output | 1 | Clear the valid bit of the Decode2 slot |
| fetch_target_req | output | 1 | Fetch the branch target speculatively |
| redirect_to_target | output | 1 | Continue decoding at the branch target |
| ex_a_sel | output | 2 | Operand A source: 00 regfile, 01 Execute result, 10 Writeback result |
| ex_b_sel | output | 2 | Operand B source, same encoding |
| d2_addr_sel | output | 2 | Decode2 address base source, same encoding |

## Verification
The bound assertions check the following on every cycle:

- flush precedence over holds;
- the taken and not-taken branch responses;
- that a Decode2 hold always drags the older stages and an Execute bubble with it;
- that a self-caused Decode1 hold never lasts two cycles;
- that register 0 or an idle slot never leaves the register file path;
- that no select takes the unused code 2'b11.

Only the bench's sequences can show the rest. That covers the select priority between the two bypass sources, which needs a Writeback history built over two cycles. It also covers the one-cycle address hold followed by the 2'b01 address select. Finally, the sequences show the overlap of a Decode1 extra cycle with a Decode2 hold, and the loss of decode progress across a flush.

// File: rtl/phc_pkg.sv
// Shared definitions for the pipeline hazard controller.
// Assumes a single register namespace in which register 0 never carries a dependency.
package phc_pkg;
    // Operand source selection code driven onto the datapath bypass muxes.
    typedef enum logic [1:0] {
        FWD_RF = 2'b00,   // value read from the register file
        FWD_EX = 2'b01,   // result Execute produced last cycle (now in Writeback)
        FWD_WB = 2'b10    // result that was written back last cycle
    } fwd_sel_e;
endpackage

// File: rtl/phc_fwd_pick.sv
// Chooses the bypass source for one register read.
// Assumes the near producer is younger than the far producer, so the near one wins a tie.
module phc_fwd_pick #(
    parameter int AW = 5
) (
    input  logic                 need,
    input  logic [AW-1:0]        src,
    input  logic                 near_wr,
    input  logic [AW-1:0]        near_dst,
    input  logic                 far_wr,
    input  logic [AW-1:0]        far_dst,
    output phc_pkg::fwd_sel_e    sel
);
    import phc_pkg::*;

    // Priority match: youngest writer first, register 0 never matches.
    always_comb begin
        sel = FWD_RF;
        if (need && (src != '0)) begin
            if (near_wr && (near_dst == src)) begin
                sel = FWD_EX;
            end else if (far_wr && (far_dst == src)) begin
                sel = FWD_WB;
            end
        end
    end
endmodule

// File: rtl/phc_extra_cycle.sv
// Tracks whether a decode stage has already spent its one extra cycle on the
// instruction it holds. Assumes the stage keeps its instruction while held.
module phc_extra_cycle (
    input  logic clk,
    input  logic rst_n,
    input  logic occupied,
    input  logic hard,
    input  logic held,
    input  logic clear,
    output logic busy
);
    logic done_q;

    // Remember that one held cycle has elapsed; forget on advance or flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (clear || !held) begin
            done_q <= 1'b0;
        end else if (occupied && hard) begin
            done_q <= 1'b1;
        end
    end

    // The stage still needs its extra cycle.
    assign busy = occupied && hard && !done_q;
endmodule

// File: rtl/phc_stall_ctrl.sv
// Turns the stall causes into per-stage holds and bubbles.
// Assumes a held stage also holds every stage behind it, and a flush cancels all holds.
module phc_stall_ctrl (
    input  logic d1_busy,
    input  logic d2_busy,
    input  logic addr_hazard,
    input  logic flush,
    output logic hold_f,
    output logic hold_d1,
    output logic hold_d2,
    output logic bubble_d2,
    output logic bubble_ex
);
    logic d2_stop;
    logic d1_stop;

    // Combine causes, letting a flush win and stalls propagate to older stages.
    always_comb begin
        d2_stop   = (d2_busy || addr_hazard) && !flush;
        d1_stop   = (d1_busy || d2_stop) && !flush;
        hold_d2   = d2_stop;
        hold_d1   = d1_stop;
        hold_f    = d1_stop;
        bubble_ex = d2_stop;
        bubble_d2 = d1_stop && !d2_stop;
    end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
// Hazard controller for a Fetch / Decode1 / Decode2 / Execute / Writeback pipeline.
// Produces holds, bubbles, flushes, the branch redirect and the bypass selects.
// Assumes the datapath applies holds and flushes at the next clock edge and that
// the register file is written at the end of Writeback.
module pipe_hazard_ctrl #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          d1_valid,
    input  logic          d1_multi_op,
    input  logic          d2_valid,
    input  logic          d2_addr_uses_reg,
    input  logic [AW-1:0] d2_addr_reg,
    input  logic          d2_has_index,
    input  logic          d2_disp_and_imm,
    input  logic          ex_valid,
    input  logic [AW-1:0] ex_src_a,
    input  logic [AW-1:0] ex_src_b,
    input  logic          ex_uses_b,
    input  logic          ex_is_store,
    input  logic [AW-1:0] ex_dst,
    input  logic          ex_writes,
    input  logic          ex_is_branch,
    input  logic          ex_taken,
    input  logic          wb_valid,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_writes,
    output logic          hold_f,
    output logic          hold_d1,
    output logic          hold_d2,
    output logic          bubble_d2,
    output logic          bubble_ex,
    output logic          flush_f,
    output logic          flush_d1,
    output logic          flush_d2,
    output logic          fetch_target_req,
    output logic          redirect_to_target,
    output logic [1:0]    ex_a_sel,
    output logic [1:0]    ex_b_sel,
    output logic [1:0]    d2_addr_sel
);
    import phc_pkg::*;

    localparam int NUM_DEC = 2;   // Decode1, Decode2
    localparam int NUM_RD  = 3;   // operand A, operand B, address base

    logic          taken_q_free;
    logic          ret_wr_q;
    logic [AW-1:0] ret_dst_q;
    logic          addr_hazard;

    logic [NUM_DEC-1:0] dec_occ;
    logic [NUM_DEC-1:0] dec_hard;
    logic [NUM_DEC-1:0] dec_held;
    logic [NUM_DEC-1:0] dec_busy;

    logic [NUM_RD-1:0]  rd_need;
    logic [AW-1:0]      rd_src [NUM_RD];
    fwd_sel_e           rd_sel [NUM_RD];

    // Branch resolution: predict not taken, redirect and flush on taken.
    always_comb begin
        fetch_target_req   = ex_valid && ex_is_branch;
        taken_q_free       = ex_valid && ex_is_branch && ex_taken;
        redirect_to_target = taken_q_free;
        flush_f            = taken_q_free;
        flush_d1           = taken_q_free;
        flush_d2           = taken_q_free;
    end

    // Remember what left Writeback last cycle, for the second bypass source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_wr_q  <= 1'b0;
            ret_dst_q <= '0;
        end else begin
            ret_wr_q  <= wb_valid && wb_writes;
            ret_dst_q <= wb_dst;
        end
    end

    // Address base needed in Decode2 while its producer is still in Execute.
    always_comb begin
        addr_hazard = d2_valid && d2_addr_uses_reg && (d2_addr_reg != '0)
                   && ex_valid && ex_writes && (ex_dst == d2_addr_reg);
    end

    // Decode stage descriptors, index 0 = Decode1, index 1 = Decode2.
    assign dec_occ  = {d2_valid, d1_valid};
    assign dec_hard = {d2_has_index || d2_disp_and_imm, d1_multi_op};
    assign dec_held = {hold_d2, hold_d1};

    // One extra-cycle tracker per decode stage.
    for (genvar g = 0; g < NUM_DEC; g++) begin : g_dec
        phc_extra_cycle u_extra (
            .clk      (clk),
            .rst_n    (rst_n),
            .occupied (dec_occ[g]),
            .hard     (dec_hard[g]),
            .held     (dec_held[g]),
            .clear    (taken_q_free),
            .busy     (dec_busy[g])
        );
    end

    phc_stall_ctrl u_stall (
        .d1_busy     (dec_busy[0]),
        .d2_busy     (dec_busy[1]),
        .addr_hazard (addr_hazard),
        .flush       (taken_q_free),
        .hold_f      (hold_f),
        .hold_d1     (hold_d1),
        .hold_d2     (hold_d2),
        .bubble_d2   (bubble_d2),
        .bubble_ex   (bubble_ex)
    );

    // Register reads to forward, index 0 = A, 1 = B / store data, 2 = address.
    assign rd_need   = {d2_valid && d2_addr_uses_reg,
                        ex_valid && (ex_uses_b || ex_is_store),
                        ex_valid};
    assign rd_src[0] = ex_src_a;
    assign rd_src[1] = ex_src_b;
    assign rd_src[2] = d2_addr_reg;

    // One bypass picker per register read; all share the same producer set.
    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
        phc_fwd_pick #(.AW(AW)) u_pick (
            .need     (rd_need[r]),
            .src      (rd_src[r]),
            .near_wr  (wb_valid && wb_writes),
            .near_dst (wb_dst),
            .far_wr   (ret_wr_q),
            .far_dst  (ret_dst_q),
            .sel      (rd_sel[r])
        );
    end

    assign ex_a_sel    = rd_sel[0];
    assign ex_b_sel    = rd_sel[1];
    assign d2_addr_sel = rd_sel[2];
endmodule

// File: rtl/phc_checker.sv
// Cycle-by-cycle properties of the hazard controller, bound to its top module.
// Assumes only port-level visibility of the controller.
module phc_checker #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          d1_valid,
    input logic          ex_valid,
    input logic [AW-1:0] ex_src_a,
    input logic          ex_is_branch,
    input logic          ex_taken,
    input logic          hold_f,
    input logic          hold_d1,
    input logic          hold_d2,
    input logic          bubble_d2,
    input logic          bubble_ex,
    input logic          flush_f,
    input logic          flush_d1,
    input logic          flush_d2,
    input logic          fetch_target_req,
    input logic          redirect_to_target,
    input logic [1:0]    ex_a_sel,
    input logic [1:0]    ex_b_sel,
    input logic [1:0]    d2_addr_sel
);
    // R1: a Decode1 hold of its own never repeats in the next cycle.
    p_d1_one_extra_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_d1 && !hold_d2 && d1_valid) |=> !(hold_d1 && !hold_d2));

    // R2: a Decode2 hold freezes the older stages and bubbles Execute.
    p_d2_chain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hold_d2 |-> (hold_d1 && hold_f && bubble_ex && !bubble_d2));

    // R5: the unused select code never appears.
    p_sel_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_a_sel != 2'b11) && (ex_b_sel != 2'b11) && (d2_addr_sel != 2'b11));

    // R7: register 0 or an idle Execute slot reads the register file.
    p_reg0_rf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_valid || (ex_src_a == '0)) |-> (ex_a_sel == 2'b00));

    // R9: a taken branch flushes and redirects.
    p_taken_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_is_branch && ex_taken) |->
        (flush_f && flush_d1 && flush_d2 && redirect_to_target && fetch_target_req));

    // R10: a not-taken branch only requests the target fetch.
    p_not_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_is_branch && !ex_taken) |->
        (fetch_target_req && !redirect_to_target && !flush_d1 && !flush_d2 && !flush_f));

    // R11: a flush removes every hold and bubble.
    p_flush_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_d2 |-> !(hold_f || hold_d1 || hold_d2 || bubble_d2 || bubble_ex));
endmodule

bind pipe_hazard_ctrl phc_checker #(.AW(AW)) chk_i (
    .clk                (clk),
    .rst_n              (rst_n),
    .d1_valid           (d1_valid),
    .ex_valid           (ex_valid),
    .ex_src_a           (ex_src_a),
    .ex_is_branch       (ex_is_branch),
    .ex_taken           (ex_taken),
    .hold_f             (hold_f),
    .hold_d1            (hold_d1),
    .hold_d2            (hold_d2),
    .bubble_d2          (bubble_d2),
    .bubble_ex          (bubble_ex),
    .flush_f            (flush_f),
    .flush_d1           (flush_d1),
    .flush_d2           (flush_d2),
    .fetch_target_req   (fetch_target_req),
    .redirect_to_target (redirect_to_target),
    .ex_a_sel           (ex_a_sel),
    .ex_b_sel           (ex_b_sel),
    .d2_addr_sel        (d2_addr_sel)
);

// File: tb/pipe_hazard_ctrl_tb_top.sv
`timescale 1ns/1ps
// Sweeping bench for the hazard controller with 2-bit register numbers.
module pipe_hazard_ctrl_tb_top;
    localparam int AW = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic          rst_n;
    logic          d1_valid, d1_multi_op;
    logic          d2_valid, d2_addr_uses_reg, d2_has_index, d2_disp_and_imm;
    logic [AW-1:0] d2_addr_reg;
    logic          ex_valid, ex_uses_b, ex_is_store, ex_writes, ex_is_branch, ex_taken;
    logic [AW-1:0] ex_src_a, ex_src_b, ex_dst;
    logic          wb_valid, wb_writes;
    logic [AW-1:0] wb_dst;
    logic          hold_f, hold_d1, hold_d2, bubble_d2, bubble_ex;
    logic          flush_f, flush_d1, flush_d2, fetch_target_req, redirect_to_target;
    logic [1:0]    ex_a_sel, ex_b_sel, d2_addr_sel;

    int  n_chk = 0;
    int  n_err = 0;
    bit  finished = 1'b0;

    pipe_hazard_ctrl #(.AW(AW)) dut_i (.*);

    // Compare one value and count the result.
    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Holds and bubbles packed as {hold_f, hold_d1, hold_d2, bubble_d2, bubble_ex}.
    task automatic chk_stall(input string tag, input int exp);
        chk(tag, int'({hold_f, hold_d1, hold_d2, bubble_d2, bubble_ex}), exp);
    endtask

    // Branch outputs packed as {flush_f, flush_d1, flush_d2, redirect, target fetch}.
    task automatic chk_br(input string tag, input int exp);
        chk(tag, int'({flush_f, flush_d1, flush_d2, redirect_to_target, fetch_target_req}), exp);
    endtask

    // Drive every descriptor to its empty value.
    task automatic idle();
        d1_valid = 0; d1_multi_op = 0;
        d2_valid = 0; d2_addr_uses_reg = 0; d2_addr_reg = '0;
        d2_has_index = 0; d2_disp_and_imm = 0;
        ex_valid = 0; ex_src_a = '0; ex_src_b = '0; ex_uses_b = 0; ex_is_store = 0;
        ex_dst = '0; ex_writes = 0; ex_is_branch = 0; ex_taken = 0;
        wb_valid = 0; wb_dst = '0; wb_writes = 0;
    endtask

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL all act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R12: reset with stale Writeback activity, which must be forgotten.
        rst_n = 1'b0;
        idle();
        wb_valid = 1; wb_writes = 1; wb_dst = 2'd1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle();
        ex_valid = 1; ex_src_a = 2'd1;
        #2;
        chk("R12 a_sel", ex_a_sel, 0);
        chk_stall("R12 holds", 0);
        chk_br("R12 branch", 0);

        // R4 R5 R6 R7: sweep source, near and far producers.
        for (int s = 0; s < 4; s++)
            for (int nd = 0; nd < 4; nd++)
                for (int fd = 0; fd < 4; fd++)
                    for (int nw = 0; nw < 2; nw++)
                        for (int fw = 0; fw < 2; fw++) begin
                            int e;
                            @(negedge clk);
                            idle();
                            wb_valid = 1; wb_writes = fw[0]; wb_dst = AW'(fd);
                            @(negedge clk);
                            idle();
                            wb_valid = 1; wb_writes = nw[0]; wb_dst = AW'(nd);
                            ex_valid = 1; ex_src_a = AW'(s); ex_src_b = AW'(s); ex_is_store = 1;
                            d2_valid = 1; d2_addr_uses_reg = 1; d2_addr_reg = AW'(s);
                            #2;
                            if (s == 0) e = 0;
                            else if (nw == 1 && nd == s) e = 1;
                            else if (fw == 1 && fd == s) e = 2;
                            else e = 0;
                            chk(s == 0 ? "R7 a_sel" : "R4/R5 a_sel", ex_a_sel, e);
                            chk("R6 store b_sel", ex_b_sel, e);
                            chk("R5 addr_sel", d2_addr_sel, e);
                        end

        // R6: operand B unused, then used as an ALU input.
        @(negedge clk);
        idle();
        wb_valid = 1; wb_writes = 1; wb_dst = 2'd3;
        ex_valid = 1; ex_src_b = 2'd3;
        #2;
        chk("R6 b unused", ex_b_sel, 0);
        ex_uses_b = 1;
        #1;
        chk("R6 b used", ex_b_sel, 1);
        // R7: idle Execute slot never forwards.
        ex_valid = 0; ex_src_a = 2'd3;
        #1;
        chk("R7 idle a_sel", ex_a_sel, 0);

        // R8: address dependency on an Execute producer.
        for (int ar = 0; ar < 4; ar++)
            for (int dd = 0; dd < 4; dd++)
                for (int wr = 0; wr < 2; wr++)
                    for (int us = 0; us < 2; us++) begin
                        bit hz;
                        @(negedge clk);
                        idle();
                        d2_valid = 1; d2_addr_uses_reg = us[0]; d2_addr_reg = AW'(ar);
                        ex_valid = 1; ex_writes = wr[0]; ex_dst = AW'(dd);
                        #2;
                        hz = (us == 1) && (ar != 0) && (wr == 1) && (dd == ar);
                        chk_stall(ar == 0 ? "R7 addr reg0" : "R8 addr hold", hz ? 5'b11101 : 0);
                        if (hz) begin
                            @(negedge clk);
                            idle();
                            d2_valid = 1; d2_addr_uses_reg = 1; d2_addr_reg = AW'(ar);
                            wb_valid = 1; wb_writes = 1; wb_dst = AW'(dd);
                            #2;
                            chk_stall("R8 release", 0);
                            chk("R8 addr_sel", d2_addr_sel, 1);
                        end
                        @(negedge clk);
                        idle();
                    end

        // R1: Decode1 extra cycle.
        @(negedge clk);
        idle(); d1_multi_op = 1;
        #2; chk_stall("R1 invalid", 0);
        d1_valid = 1;
        #1; chk_stall("R1 first", 5'b11010);
        @(negedge clk);
        #2; chk_stall("R1 second", 0);
        @(negedge clk);
        d1_multi_op = 0;
        #2; chk_stall("R1 easy", 0);
        @(negedge clk);
        d1_multi_op = 1;
        #2; chk_stall("R1 again", 5'b11010);
        @(negedge clk);
        idle();

        // R2: Decode2 extra cycle for each flag combination.
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            idle();
            d2_valid = 1; d2_has_index = k[0]; d2_disp_and_imm = k[1];
            #2; chk_stall("R2 first", (k != 0) ? 5'b11101 : 0);
            @(negedge clk);
            #2; chk_stall("R2 second", 0);
            @(negedge clk);
            idle();
        end

        // R3: Decode1 extra cycle overlapped with a Decode2 hold.
        @(negedge clk);
        idle();
        d1_valid = 1; d1_multi_op = 1; d2_valid = 1; d2_has_index = 1;
        #2; chk_stall("R3 overlap", 5'b11101);
        @(negedge clk);
        d2_has_index = 0;
        #2; chk_stall("R3 after", 0);
        @(negedge clk);
        idle();

        // R9 R11: taken branch while every stall cause is present.
        @(negedge clk);
        idle();
        d1_valid = 1; d1_multi_op = 1;
        d2_valid = 1; d2_has_index = 1; d2_addr_uses_reg = 1; d2_addr_reg = 2'd2;
        ex_valid = 1; ex_writes = 1; ex_dst = 2'd2; ex_is_branch = 1; ex_taken = 1;
        #2;
        chk_br("R9 taken", 5'b11111);
        chk_stall("R11 flush wins", 0);
        @(negedge clk);
        idle();
        d1_valid = 1; d1_multi_op = 1;
        #2; chk_stall("R11 target hard", 5'b11010);
        @(negedge clk);
        idle();

        // R10: not-taken branch and a non-branch.
        @(negedge clk);
        idle();
        ex_valid = 1; ex_is_branch = 1;
        #2;
        chk_br("R10 not taken", 5'b00001);
        chk_stall("R10 no hold", 0);
        ex_valid = 0; ex_taken = 1;
        #1;
        chk_br("R10 invalid branch", 0);
        @(negedge clk);
        idle();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule